// File: doc/BRIEF.md
# Rank Idle Activity Tracker

This block follows the activity of one memory rank so that a power controller can decide when the rank may sleep. It keeps three counts: reads waiting in the queue for this rank, writes waiting in the queue, and events still in flight. In-flight events are issued reads awaiting data, a pending precharge completion, the write-done timer, and a pending refresh. From these counts and two level inputs (the direction the bus takes next, and whether a refresh is running), it produces a low-power-ready flag and a force-self-refresh-exit flag.

Three small state machines feed the in-flight count. Two are instances of one tracker: one for the precharge completion and one for the pending refresh. Each has the states TRK_IDLE and TRK_PEND. TRK_IDLE moves to TRK_PEND on its start pulse and adds one event. TRK_PEND moves back to TRK_IDLE on its finish pulse and removes one event. A start pulse in TRK_PEND and a finish pulse in TRK_IDLE do nothing. The write-done timer has the states TMR_IDLE and TMR_ARMED. TMR_IDLE moves to TMR_ARMED when a write is issued, loading the write's ready delay and adding one event. TMR_ARMED stays armed while counting down, reloads on a later ready time, and returns to TMR_IDLE on expiry, removing one event.

Top module: `rank_idle_tracker`

## Requirements
- R1: `rd_count` rises by one one cycle after `rd_enq` and falls by one one cycle after `rd_resp`.
- R2: `wr_count` rises by one one cycle after `wr_enq` and falls by one one cycle after `wr_issue`.
- R3: `rd_issue` adds one to `flight_count` and `rd_resp` removes one, each visible one cycle later.
- R4: `pre_sched` adds one in-flight event only when no precharge completion is already pending; a repeat while pending changes nothing. `pre_done` while pending removes one. `pre_done` while none is pending is ignored.
- R5: `wr_issue` with the timer idle arms the timer with delay D (`wr_dly`, where 0 counts as 1) and adds one event. The event is removed D cycles after the issue edge. An issue while the timer is armed reloads the timer only if D exceeds the cycles remaining, and never adds an event.
- R6: `ref_start` adds one in-flight event when no refresh is pending. `ref_done` removes it. Repeats of either are ignored.
- R7: The queues count as empty when `next_dir_wr`=0 (read next) and `rd_count` is 0, or when `next_dir_wr`=1 (write next) and `wr_count` is 0.
- R8: `lp_ready` equals the queue-empty term of R7 while `ref_running`=1. Otherwise it also requires `flight_count` to be 0.
- R9: `force_sref_exit` is 1 when `rd_count` is nonzero, or when `next_dir_wr`=1 and `wr_count` is nonzero.
- R10: If the removals in a cycle exceed the current `flight_count` plus that cycle's additions, the count is held and `flight_err` is set. `flight_err` stays set until reset.
- R11: All counts saturate. They stay at 2^CNT_W-1 on further net increase, and the queue counts stay at 0 on a decrement at zero.
- R12: An increment and a decrement of the same count in one cycle leave it unchanged. For `flight_count`, the change in a cycle is the number of additions minus the number of removals.
- R13: After reset, all counts are 0, `flight_err` is 0, and both trackers and the timer are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_enq | input | 1 | A read burst for this rank entered the queue |
| wr_enq | input | 1 | A new, non-merged write burst entered the queue |
| rd_issue | input | 1 | A read was issued to the rank |
| rd_resp | input | 1 | A read response was returned |
| wr_issue | input | 1 | A write left the queue and was issued |
| wr_dly | input | DLY_W | Cycles from the write issue to its ready time |
| pre_sched | input | 1 | A precharge completion was scheduled |
| pre_done | input | 1 | The precharge completed |
| ref_start | input | 1 | A refresh became pending |
| ref_done | input | 1 | The refresh completed |
| ref_running | input | 1 | A refresh is running |
| next_dir_wr | input | 1 | Next bus direction: 0 read, 1 write |
| rd_count | output | CNT_W | Queued read entries |
| wr_count | output | CNT_W | Queued write entries |
| flight_count | output | CNT_W | In-flight events |
| lp_ready | output | 1 | The rank may enter low power |
| force_sref_exit | output | 1 | A self-refresh exit should be forced |
| flight_err | output | 1 | Sticky in-flight underflow flag |

## Verification
The bench goes after several corner cases. The first is a write issued while the timer is still armed. A design that re-armed the timer unconditionally would count the event twice, and `flight_count` would never drain to zero. The second is a precharge rescheduled while one is pending; counting it twice leaves `lp_ready` stuck low. The third is `lp_ready` during a running refresh, where ignoring the mask would hold off power-down after the refresh. The fourth is a simultaneous increment and decrement, and removals at zero, where a wrapping counter would jump to its maximum. A long sweep drives every combination of pulses, levels and delays in a scrambled order, with counts small enough to hit both saturation limits.

// File: rtl/rit_pkg.sv
package rit_pkg;

    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_ARMED = 1'b1
    } tmr_state_e;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_PEND = 1'b1
    } trk_state_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } bus_dir_e;

    localparam int NUM_TRACKERS = 2;
    localparam int FLIGHT_SRCS  = 4;

endpackage

// File: rtl/rit_sat_counter.sv
module rit_sat_counter #(
    parameter int W    = 4,
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] inc,
    input  logic [NSRC-1:0] dec,
    output logic [W-1:0]    cnt,
    output logic            undf
);
    localparam int SW = W + $clog2(NSRC + 1) + 1;
    localparam logic [SW-1:0] MAXV = SW'((64'd1 << W) - 64'd1);

    logic [SW-1:0] n_inc;
    logic [SW-1:0] n_dec;
    logic [SW-1:0] sum;
    logic [SW-1:0] diff;
    logic [W-1:0]  cnt_n;

    always_comb begin
        n_inc = '0;
        n_dec = '0;
        for (int i = 0; i < NSRC; i++) begin
            n_inc = n_inc + SW'(inc[i]);
            n_dec = n_dec + SW'(dec[i]);
        end
        sum  = SW'(cnt) + n_inc;
        diff = '0;
        undf = 1'b0;
        if (sum < n_dec) begin
            undf  = 1'b1;
            cnt_n = cnt;
        end else begin
            diff = sum - n_dec;
            if (diff > MAXV) begin
                cnt_n = MAXV[W-1:0];
            end else begin
                cnt_n = diff[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_n;
        end
    end

endmodule

// File: rtl/rit_event_tracker.sv
module rit_event_tracker
    import rit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    output logic add_evt,
    output logic del_evt
);
    trk_state_e state_q;
    trk_state_e state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        add_evt = 1'b0;
        del_evt = 1'b0;
        unique case (state_q)
            TRK_IDLE: begin
                if (start) begin
                    state_n = TRK_PEND;
                    add_evt = 1'b1;
                end
            end
            TRK_PEND: begin
                if (finish) begin
                    state_n = TRK_IDLE;
                    del_evt = 1'b1;
                end
            end
            default: state_n = TRK_IDLE;
        endcase
    end

endmodule

// File: rtl/rit_wdone_timer.sv
module rit_wdone_timer
    import rit_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [DLY_W-1:0] dly,
    output logic             arm_new,
    output logic             expire
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    tmr_state_e       state_q;
    tmr_state_e       state_n;
    logic [DLY_W-1:0] rem_q;
    logic [DLY_W-1:0] rem_n;
    logic [DLY_W-1:0] eff;

    assign eff = (dly == '0) ? ONE : dly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_n;
            rem_q   <= rem_n;
        end
    end

    always_comb begin
        state_n = state_q;
        rem_n   = rem_q;
        arm_new = 1'b0;
        expire  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (issue) begin
                    state_n = TMR_ARMED;
                    rem_n   = eff;
                    arm_new = 1'b1;
                end
            end
            TMR_ARMED: begin
                if (issue && (eff > rem_q)) begin
                    rem_n = eff;
                end else if (rem_q <= ONE) begin
                    state_n = TMR_IDLE;
                    rem_n   = '0;
                    expire  = 1'b1;
                end else begin
                    rem_n = rem_q - ONE;
                end
            end
            default: begin
                state_n = TMR_IDLE;
                rem_n   = '0;
            end
        endcase
    end

endmodule

// File: rtl/rank_idle_tracker.sv
module rank_idle_tracker
    import rit_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_enq,
    input  logic             wr_enq,
    input  logic             rd_issue,
    input  logic             rd_resp,
    input  logic             wr_issue,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic             pre_sched,
    input  logic             pre_done,
    input  logic             ref_start,
    input  logic             ref_done,
    input  logic             ref_running,
    input  logic             next_dir_wr,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] wr_count,
    output logic [CNT_W-1:0] flight_count,
    output logic             lp_ready,
    output logic             force_sref_exit,
    output logic             flight_err
);
    logic [NUM_TRACKERS-1:0] trk_start;
    logic [NUM_TRACKERS-1:0] trk_finish;
    logic [NUM_TRACKERS-1:0] trk_add;
    logic [NUM_TRACKERS-1:0] trk_del;
    logic                    tmr_arm;
    logic                    tmr_exp;
    logic [FLIGHT_SRCS-1:0]  fl_inc;
    logic [FLIGHT_SRCS-1:0]  fl_dec;
    logic                    fl_undf;
    logic                    rd_undf_unused;
    logic                    wr_undf_unused;
    logic                    queues_empty;
    bus_dir_e                dir;
    logic                    err_q;

    // index 0: precharge completion, index 1: pending refresh
    assign trk_start  = {ref_start, pre_sched};
    assign trk_finish = {ref_done,  pre_done};

    for (genvar g = 0; g < NUM_TRACKERS; g++) begin : g_trk
        rit_event_tracker u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (trk_start[g]),
            .finish  (trk_finish[g]),
            .add_evt (trk_add[g]),
            .del_evt (trk_del[g])
        );
    end

    rit_wdone_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (wr_issue),
        .dly     (wr_dly),
        .arm_new (tmr_arm),
        .expire  (tmr_exp)
    );

    rit_sat_counter #(.W(CNT_W), .NSRC(1)) u_rd_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rd_enq),
        .dec   (rd_resp),
        .cnt   (rd_count),
        .undf  (rd_undf_unused)
    );

    rit_sat_counter #(.W(CNT_W), .NSRC(1)) u_wr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_enq),
        .dec   (wr_issue),
        .cnt   (wr_count),
        .undf  (wr_undf_unused)
    );

    assign fl_inc = {rd_issue, tmr_arm, trk_add[1], trk_add[0]};
    assign fl_dec = {rd_resp,  tmr_exp, trk_del[1], trk_del[0]};

    rit_sat_counter #(.W(CNT_W), .NSRC(FLIGHT_SRCS)) u_fl_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fl_inc),
        .dec   (fl_dec),
        .cnt   (flight_count),
        .undf  (fl_undf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (fl_undf) begin
            err_q <= 1'b1;
        end
    end

    assign flight_err = err_q;
    assign dir        = bus_dir_e'(next_dir_wr);

    always_comb begin
        unique case (dir)
            DIR_RD:  queues_empty = (rd_count == '0);
            DIR_WR:  queues_empty = (wr_count == '0);
            default: queues_empty = 1'b0;
        endcase
        lp_ready        = queues_empty && (ref_running || (flight_count == '0));
        force_sref_exit = (rd_count != '0) || ((dir == DIR_WR) && (wr_count != '0));
    end

endmodule

// File: rtl/rit_checker.sv
module rit_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_enq,
    input logic             rd_resp,
    input logic             wr_enq,
    input logic             wr_issue,
    input logic             ref_running,
    input logic [CNT_W-1:0] rd_count,
    input logic [CNT_W-1:0] wr_count,
    input logic [CNT_W-1:0] flight_count,
    input logic             lp_ready,
    input logic             force_sref_exit,
    input logic             flight_err
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    p_wr_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enq && !wr_issue && wr_count != MAXV) |=> (wr_count == $past(wr_count) + 1'b1));

    p_lp_needs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_ready && !ref_running) |-> (flight_count == '0));

    p_force_on_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count != '0) |-> force_sref_exit);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flight_err |=> flight_err);

    p_err_holds_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flight_err) |-> $stable(flight_count));

    p_rd_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count == MAXV && !rd_resp) |=> (rd_count == MAXV));

    p_rd_balance_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_enq && rd_resp) |=> $stable(rd_count));

endmodule

bind rank_idle_tracker rit_checker #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_enq          (rd_enq),
    .rd_resp         (rd_resp),
    .wr_enq          (wr_enq),
    .wr_issue        (wr_issue),
    .ref_running     (ref_running),
    .rd_count        (rd_count),
    .wr_count        (wr_count),
    .flight_count    (flight_count),
    .lp_ready        (lp_ready),
    .force_sref_exit (force_sref_exit),
    .flight_err      (flight_err)
);

// File: tb/tb_rank_idle_tracker.sv
module tb_rank_idle_tracker;
    localparam int CW   = 3;
    localparam int DW   = 4;
    localparam int MAXC = 7;

    localparam logic [14:0] B_RENQ = 15'h0001;
    localparam logic [14:0] B_WENQ = 15'h0002;
    localparam logic [14:0] B_RISS = 15'h0004;
    localparam logic [14:0] B_RRSP = 15'h0008;
    localparam logic [14:0] B_WISS = 15'h0010;
    localparam logic [14:0] B_PSCH = 15'h0020;
    localparam logic [14:0] B_PDON = 15'h0040;
    localparam logic [14:0] B_RSTA = 15'h0080;
    localparam logic [14:0] B_RDON = 15'h0100;
    localparam logic [14:0] B_RRUN = 15'h0200;
    localparam logic [14:0] B_DIRW = 15'h0400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_enq = 0, wr_enq = 0, rd_issue = 0, rd_resp = 0, wr_issue = 0;
    logic pre_sched = 0, pre_done = 0, ref_start = 0, ref_done = 0;
    logic ref_running = 0, next_dir_wr = 0;
    logic [DW-1:0] wr_dly = '0;
    logic [CW-1:0] rd_count, wr_count, flight_count;
    logic lp_ready, force_sref_exit, flight_err;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    int m_rd = 0, m_wr = 0, m_fl = 0, m_err = 0;
    int m_pre = 0, m_ref = 0, m_tarm = 0, m_rem = 0;

    always #5 clk = ~clk;

    rank_idle_tracker #(.CNT_W(CW), .DLY_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .rd_enq(rd_enq), .wr_enq(wr_enq),
        .rd_issue(rd_issue), .rd_resp(rd_resp), .wr_issue(wr_issue),
        .wr_dly(wr_dly), .pre_sched(pre_sched), .pre_done(pre_done),
        .ref_start(ref_start), .ref_done(ref_done), .ref_running(ref_running),
        .next_dir_wr(next_dir_wr), .rd_count(rd_count), .wr_count(wr_count),
        .flight_count(flight_count), .lp_ready(lp_ready),
        .force_sref_exit(force_sref_exit), .flight_err(flight_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int sat(input int v);
        if (v > MAXC) return MAXC;
        return v;
    endfunction

    task automatic model_update();
        int inc, dec, d, t_arm, t_exp, p_inc, p_dec, r_inc, r_dec;
        t_arm = 0; t_exp = 0;
        d = (wr_dly == 0) ? 1 : int'(wr_dly);
        if (m_tarm == 0) begin
            if (wr_issue) begin m_tarm = 1; m_rem = d; t_arm = 1; end
        end else if (wr_issue && d > m_rem) begin
            m_rem = d;
        end else if (m_rem <= 1) begin
            m_tarm = 0; m_rem = 0; t_exp = 1;
        end else begin
            m_rem = m_rem - 1;
        end
        p_inc = (m_pre == 0 && pre_sched) ? 1 : 0;
        p_dec = (m_pre == 1 && pre_done) ? 1 : 0;
        if (p_inc == 1) m_pre = 1; else if (p_dec == 1) m_pre = 0;
        r_inc = (m_ref == 0 && ref_start) ? 1 : 0;
        r_dec = (m_ref == 1 && ref_done) ? 1 : 0;
        if (r_inc == 1) m_ref = 1; else if (r_dec == 1) m_ref = 0;
        inc = int'(rd_issue) + t_arm + p_inc + r_inc;
        dec = int'(rd_resp) + t_exp + p_dec + r_dec;
        if (m_fl + inc < dec) m_err = 1; else m_fl = sat(m_fl + inc - dec);
        if (m_rd + int'(rd_enq) >= int'(rd_resp)) m_rd = sat(m_rd + int'(rd_enq) - int'(rd_resp));
        if (m_wr + int'(wr_enq) >= int'(wr_issue)) m_wr = sat(m_wr + int'(wr_enq) - int'(wr_issue));
    endtask

    task automatic compare_all();
        int empty, exp_lp, exp_force;
        empty = next_dir_wr ? (m_wr == 0) : (m_rd == 0);
        exp_lp = (empty != 0) && (ref_running || m_fl == 0);
        exp_force = (m_rd != 0) || (next_dir_wr && m_wr != 0);
        check("R1 rd_count", int'(rd_count), m_rd);
        check("R2 wr_count", int'(wr_count), m_wr);
        check("R3 flight_count", int'(flight_count), m_fl);
        check("R10 flight_err", int'(flight_err), m_err);
        check("R8 lp_ready", int'(lp_ready), exp_lp);
        check("R9 force_sref_exit", int'(force_sref_exit), exp_force);
    endtask

    task automatic step(input logic [14:0] v);
        @(negedge clk);
        rd_enq = v[0]; wr_enq = v[1]; rd_issue = v[2]; rd_resp = v[3];
        wr_issue = v[4]; pre_sched = v[5]; pre_done = v[6]; ref_start = v[7];
        ref_done = v[8]; ref_running = v[9]; next_dir_wr = v[10]; wr_dly = v[14:11];
        @(posedge clk);
        #1;
        model_update();
        compare_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state
        check("R13 rd_count", int'(rd_count), 0);
        check("R13 wr_count", int'(wr_count), 0);
        check("R13 flight_count", int'(flight_count), 0);
        check("R13 flight_err", int'(flight_err), 0);
        check("R13 lp_ready", int'(lp_ready), 1);
        check("R13 force_sref_exit", int'(force_sref_exit), 0);

        // R5: arm with delay 3, event lives 3 cycles
        step(B_WENQ);
        step(B_WISS | (15'd3 << 11));
        check("R5 armed", int'(flight_count), 1);
        step('0);
        check("R5 counting", int'(flight_count), 1);
        step('0);
        check("R5 last cycle", int'(flight_count), 1);
        step('0);
        check("R5 expired", int'(flight_count), 0);
        // R5: reissue while armed with a later time extends, no second event
        step(B_WISS | (15'd2 << 11));
        step(B_WISS | (15'd5 << 11));
        check("R5 extend no add", int'(flight_count), 1);
        repeat (4) step('0);
        check("R5 extended still armed", int'(flight_count), 1);
        step('0);
        check("R5 extended expired", int'(flight_count), 0);

        // R4: reschedule of a pending precharge does not count twice
        step(B_PSCH);
        step(B_PSCH);
        check("R4 single count", int'(flight_count), 1);
        step(B_PDON);
        check("R4 done", int'(flight_count), 0);

        // R6 with R8: pending refresh blocks, running refresh masks
        step(B_RSTA);
        check("R6 pending", int'(flight_count), 1);
        check("R6 blocks lp", int'(lp_ready), 0);
        step(B_RSTA | B_RRUN);
        check("R8 masked while running", int'(lp_ready), 1);
        step(B_RDON);
        check("R6 complete", int'(flight_count), 0);

        // R7: direction picks which queue must be empty
        step(B_WENQ);
        check("R7 read dir ignores writes", int'(lp_ready), 1);
        step(B_DIRW);
        check("R7 write dir sees writes", int'(lp_ready), 0);
        check("R9 write dir forces exit", int'(force_sref_exit), 1);
        step(B_WISS | B_DIRW | (15'd1 << 11));
        step(B_DIRW);

        // R11: saturation at maximum and at zero
        repeat (9) step(B_RENQ);
        check("R11 rd saturates", int'(rd_count), MAXC);
        // R12: simultaneous increment and decrement
        step(B_RENQ | B_RRSP | B_RISS);
        check("R12 rd unchanged", int'(rd_count), MAXC);
        repeat (8) step(B_RRSP | B_RISS);
        check("R11 rd floor", int'(rd_count), 0);
        repeat (8) step(B_RRSP);
        // R10: removals beyond count set sticky error and hold count
        check("R10 err set", int'(flight_err), 1);
        check("R10 count held", int'(flight_count), 0);

        // near-exhaustive scrambled sweep over every input combination
        for (int i = 0; i < 32768; i++) begin
            step(15'((i * 12345 + 7) & 32'h7fff));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule